// File: doc/BRIEF.md
# Two-Digit BCD Seconds Counter

This block keeps a seconds value from 00 to 59 as two binary-coded-decimal digits. The low digit runs 0 to 9 and the high digit runs 0 to 5. Every flip-flop runs on one system clock. The count moves by one step only in a cycle where the one-cycle enable tick is high. A direction input chooses whether the step goes up or down, and in either direction the value wraps around within a single step.

The enable tick comes from one of two sources, chosen at build time. It can be made inside the block by a divider with a programmable period; the default period is sixteen million cycles, which gives one tick per second from a 16 MHz clock. Otherwise it is taken straight from the `tick_in` pin. The raw reset and direction pins are asynchronous to the clock, so each is registered before any logic uses it. Reset is synchronous, active high, and returns both digits to zero.

Apart from the single register stage on these inputs, the block has no handshake at its edge. All of its pins are plain control and status lines.

Top module: `sec_bcd_counter`

## Requirements
- R1: Hold `rst_in` high through a clock edge. Two edges after it is first driven high, `digit_lo` and `digit_hi` are both 0. They stay 0 for as long as reset stays registered high.
- R2: In any cycle where the enable tick is low, neither digit changes. This holds even while `dir_in` toggles.
- R3: Counting up means `dir_in`=1. On an enabled cycle, a low digit below 9 goes up by one, and a low digit of 9 becomes 0.
- R4: Counting down means `dir_in`=0. On an enabled cycle, a low digit above 0 goes down by one, and a low digit of 0 becomes 9.
- R5: Counting up, the high digit steps only when the low digit is 9 in an enabled cycle. It goes 5→0 and otherwise up by one, so 59 wraps to 00 in a single tick.
- R6: Counting down, the high digit steps only when the low digit is 0 in an enabled cycle. It goes 0→5 and otherwise down by one, so 00 wraps to 59 in a single tick.
- R7: On an enabled cycle where the low digit is not at the terminal value for the current direction, the high digit keeps its value.
- R8: `dir_in` passes through exactly one register stage. Suppose it changes at least one edge before a tick. The tick then steps once in the new direction, with no extra step and no skipped value.
- R9: With the internal divider selected and a period of P, the digits step exactly once every P cycles. The first step after reset is released comes P+1 edges after the release is driven. In this mode `tick_in` has no effect.
- R10: The low digit never exceeds 9 and the high digit never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register uses its rising edge |
| rst_in | input | 1 | Asynchronous active-high reset request, registered once before use |
| dir_in | input | 1 | Count direction, 1 = up and 0 = down, registered once before use |
| tick_in | input | 1 | External one-cycle enable tick; ignored when the internal divider is selected |
| digit_lo | output | 4 | Low BCD digit, 0 to 9 |
| digit_hi | output | 3 | High BCD digit, 0 to 5 |

## Verification
A tick driven on `tick_in` shows up on the digits one edge later. A change on `dir_in` takes effect only from the edge after it is registered, so the driver always leaves one edge between a direction change and the following tick. Reset needs two edges: one to register it and one to clear the digits. The driver tags every expected value with the cycle count at which that value is due, and the monitor compares each one at the falling edge of that cycle. For the internal divider, the bench records the cycle number of every value change on a second instance and compares the gaps against the period.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef enum logic {
    CNT_DOWN = 1'b0,
    CNT_UP   = 1'b1
  } cnt_dir_e;

  // Next value of one modulo digit, given its top value and the direction.
  function automatic int digit_step(input int cur, input int top, input logic up);
    int nxt;
    if (up) begin
      nxt = (cur >= top) ? 0 : cur + 1;
    end else begin
      nxt = (cur == 0) ? top : cur - 1;
    end
    return nxt;
  endfunction

  // Width of a digit register able to hold 0..top.
  function automatic int digit_width(input int top);
    return (top < 1) ? 1 : $clog2(top + 1);
  endfunction

endpackage

// File: rtl/scc_in_sync.sv
module scc_in_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    pipe[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/scc_tick_div.sv
module scc_tick_div #(
  parameter int PERIOD = 16_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int CNT_W = (PERIOD < 2) ? 1 : $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/scc_bcd_digit.sv
module scc_bcd_digit
  import scc_pkg::*;
#(
  parameter int TOP = 9,
  parameter int W   = digit_width(TOP)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         up,
  output logic [W-1:0] q,
  output logic         carry
);

  logic [W-1:0] nxt;
  logic         at_top;
  logic         at_zero;

  assign at_top  = (q == W'(TOP));
  assign at_zero = (q == '0);
  assign carry   = en && (up ? at_top : at_zero);

  always_comb begin
    nxt = W'(digit_step(int'(q), TOP, up));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/sec_bcd_counter.sv
module sec_bcd_counter
  import scc_pkg::*;
#(
  parameter bit TICK_INTERNAL = 1'b1,
  parameter int TICK_PERIOD   = 16_000_000,
  parameter int LO_TOP        = 9,
  parameter int HI_TOP        = 5,
  parameter int SYNC_STAGES   = 1
) (
  input  logic                                  clk,
  input  logic                                  rst_in,
  input  logic                                  dir_in,
  input  logic                                  tick_in,
  output logic [scc_pkg::digit_width(LO_TOP)-1:0] digit_lo,
  output logic [scc_pkg::digit_width(HI_TOP)-1:0] digit_hi
);

  localparam int LO_W = digit_width(LO_TOP);
  localparam int HI_W = digit_width(HI_TOP);

  logic rst_s;
  logic dir_s;
  logic tick;
  logic lo_carry;
  logic hi_carry;

  // One register stage on the asynchronous control pins.
  scc_in_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .d   ({rst_in, dir_in}),
    .q   ({rst_s, dir_s})
  );

  generate
    if (TICK_INTERNAL) begin : g_int_tick
      scc_tick_div #(
        .PERIOD (TICK_PERIOD)
      ) u_div (
        .clk  (clk),
        .rst  (rst_s),
        .tick (tick)
      );
    end else begin : g_ext_tick
      assign tick = tick_in;
    end
  endgenerate

  scc_bcd_digit #(
    .TOP (LO_TOP),
    .W   (LO_W)
  ) u_lo (
    .clk   (clk),
    .rst   (rst_s),
    .en    (tick),
    .up    (dir_s),
    .q     (digit_lo),
    .carry (lo_carry)
  );

  // High digit is enabled only by the low digit's direction-dependent terminal.
  scc_bcd_digit #(
    .TOP (HI_TOP),
    .W   (HI_W)
  ) u_hi (
    .clk   (clk),
    .rst   (rst_s),
    .en    (lo_carry),
    .up    (dir_s),
    .q     (digit_hi),
    .carry (hi_carry)
  );

  logic unused_hi_carry;
  assign unused_hi_carry = hi_carry;

endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
  parameter int LO_TOP = 9,
  parameter int HI_TOP = 5,
  parameter int LO_W   = 4,
  parameter int HI_W   = 3
) (
  input logic            clk,
  input logic            rst_s,
  input logic            tick,
  input logic            dir_s,
  input logic [LO_W-1:0] lo,
  input logic [HI_W-1:0] hi
);

  logic seen_rst = 1'b0;

  always_ff @(posedge clk) begin
    if (rst_s === 1'b1) seen_rst <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!seen_rst)
    rst_s |=> (lo == '0) && (hi == '0)); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst_s || !seen_rst)
    !tick |=> $stable(lo) && $stable(hi)); // R2

  AST_LO_UP_STEP: assert property (@(posedge clk) disable iff (rst_s || !seen_rst)
    (tick && dir_s && lo != LO_W'(LO_TOP)) |=> lo == $past(lo) + 1'b1); // R3

  AST_LO_UP_WRAP: assert property (@(posedge clk) disable iff (rst_s || !seen_rst)
    (tick && dir_s && lo == LO_W'(LO_TOP)) |=> lo == '0); // R3

  AST_LO_DN_STEP: assert property (@(posedge clk) disable iff (rst_s || !seen_rst)
    (tick && !dir_s && lo != '0) |=> lo == $past(lo) - 1'b1); // R4

  AST_LO_DN_WRAP: assert property (@(posedge clk) disable iff (rst_s || !seen_rst)
    (tick && !dir_s && lo == '0) |=> lo == LO_W'(LO_TOP)); // R4

  AST_HI_UP_WRAP: assert property (@(posedge clk) disable iff (rst_s || !seen_rst)
    (tick && dir_s && lo == LO_W'(LO_TOP) && hi == HI_W'(HI_TOP)) |=> hi == '0); // R5

  AST_HI_DN_WRAP: assert property (@(posedge clk) disable iff (rst_s || !seen_rst)
    (tick && !dir_s && lo == '0 && hi == '0) |=> hi == HI_W'(HI_TOP)); // R6

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (rst_s || !seen_rst)
    (tick && (dir_s ? lo != LO_W'(LO_TOP) : lo != '0)) |=> $stable(hi)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst_s || !seen_rst)
    (lo <= LO_W'(LO_TOP)) && (hi <= HI_W'(HI_TOP))); // R10

endmodule

bind sec_bcd_counter scc_checker #(
  .LO_TOP (LO_TOP),
  .HI_TOP (HI_TOP),
  .LO_W   (LO_W),
  .HI_W   (HI_W)
) u_scc_checker (
  .clk   (clk),
  .rst_s (rst_s),
  .tick  (tick),
  .dir_s (dir_s),
  .lo    (digit_lo),
  .hi    (digit_hi)
);

// File: tb/test_sec_bcd_counter.sv
`timescale 1ns/1ps
module test_sec_bcd_counter;

  localparam int DIV_P = 5;

  logic clk = 1'b0;
  logic rst_in = 1'b1;
  logic dir_in = 1'b1;
  logic tick_in = 1'b0;
  logic [3:0] digit_lo;
  logic [2:0] digit_hi;
  logic [3:0] div_lo;
  logic [2:0] div_hi;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    int    lo;
    int    hi;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int m_lo = 0;
  int m_hi = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sec_bcd_counter #(
    .TICK_INTERNAL (1'b0),
    .TICK_PERIOD   (16)
  ) i_sec_bcd_counter (
    .clk      (clk),
    .rst_in   (rst_in),
    .dir_in   (dir_in),
    .tick_in  (tick_in),
    .digit_lo (digit_lo),
    .digit_hi (digit_hi)
  );

  sec_bcd_counter #(
    .TICK_INTERNAL (1'b1),
    .TICK_PERIOD   (DIV_P)
  ) i_sec_bcd_counter_div (
    .clk      (clk),
    .rst_in   (rst_in),
    .dir_in   (dir_in),
    .tick_in  (1'b1),
    .digit_lo (div_lo),
    .digit_hi (div_hi)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: compare queued expectations at the falling edge of their due cycle.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.req, " lo"}, int'(digit_lo), e.lo);
        check({e.req, " hi"}, int'(digit_hi), e.hi);
      end
    end
  end

  function automatic void model_step(input bit up);
    if (up) begin
      if (m_lo == 9) begin
        m_lo = 0;
        m_hi = (m_hi == 5) ? 0 : m_hi + 1;
      end else m_lo = m_lo + 1;
    end else begin
      if (m_lo == 0) begin
        m_lo = 9;
        m_hi = (m_hi == 0) ? 5 : m_hi - 1;
      end else m_lo = m_lo - 1;
    end
  endfunction

  task automatic push(input int delay, input string req);
    exp_t e;
    e.due = cyc + delay;
    e.lo = m_lo;
    e.hi = m_hi;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_in = 1'b1;
    m_lo = 0;
    m_hi = 0;
    push(2, "R1");
    @(negedge clk);
    @(negedge clk);
    push(1, "R1");
    rst_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_dir(input bit d);
    @(negedge clk);
    dir_in = d;
  endtask

  task automatic tick_n(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_in = 1'b1;
      model_step(dir_in);
      push(1, req);
      @(negedge clk);
      tick_in = 1'b0;
    end
  endtask

  task automatic idle_n(input int n, input bit toggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (toggle) dir_in = ~dir_in;
      push(1, "R2");
    end
  endtask

  initial begin
    do_reset();
    set_dir(1'b1);
    tick_n(9, "R3");            // 00 -> 09
    tick_n(1, "R5");            // 09 -> 10, high steps
    tick_n(3, "R7");            // 11..13, high held
    idle_n(6, 1'b1);            // direction toggles without a tick
    set_dir(1'b1);
    tick_n(46, "R3");           // 13 -> 59
    tick_n(1, "R5");            // 59 -> 00
    set_dir(1'b0);
    tick_n(1, "R6");            // 00 -> 59
    tick_n(10, "R4");           // 59 -> 49
    tick_n(4, "R7");            // 48..45
    set_dir(1'b1);
    tick_n(1, "R8");            // 46
    set_dir(1'b0);
    tick_n(1, "R8");            // 45
    set_dir(1'b1);
    tick_n(1, "R8");            // 46
    idle_n(4, 1'b0);
    do_reset();                 // mid-count reset
    set_dir(1'b0);
    tick_n(1, "R4");            // 00 -> 59
    tick_n(1, "R4");            // 58
    repeat (3) @(negedge clk);
    check("R10 lo range", int'(digit_lo) <= 9, 1);
    check("R10 hi range", int'(digit_hi) <= 5, 1);

    // Internal divider on the second instance.
    begin
      int last_chg;
      int prev_lo;
      int rel;
      set_dir(1'b1);
      @(negedge clk);
      rst_in = 1'b1;
      repeat (2) @(negedge clk);
      rst_in = 1'b0;
      rel = cyc;
      prev_lo = int'(div_lo);
      last_chg = rel;
      for (int k = 0; k < 5; k++) begin
        int guard = 0;
        while (int'(div_lo) == prev_lo && guard < 50) begin
          @(negedge clk);
          guard++;
        end
        check("R9 divider step", int'(div_lo), prev_lo + 1);
        if (k == 0) check("R9 first step", cyc - rel, DIV_P + 1);
        else        check("R9 period", cyc - last_chg, DIV_P);
        last_chg = cyc;
        prev_lo = int'(div_lo);
      end
    end

    repeat (3) @(negedge clk);
    check("queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule